// File: doc/BRIEF.md
# Spike History Shift Tracker

This block holds the firing record of a single pre-synaptic source. The record has two parts: a coarse time, which is the millisecond stamp of the most recent spike, and a fine history. The fine history is a bit map in which every position covers one 2 ms slot. When a spike arrives with its current time, the block slides the history forward by the number of whole slots that have passed. It then marks the newest slot and adopts the new time as the coarse time.

Any recorded spike that slides off the far end of the window becomes a learning-trigger event, and the event carries that spike's own time. The consumer therefore runs plasticity only once enough later history exists around the old spike. Events leave one at a time over a valid/ready handshake. While an event waits, the slide stops. A slot-indexed query port returns whether a given history slot holds a spike and which time that slot stands for.

Top module: `stdp_hist_tracker`

## Requirements
- R1: A synchronous reset empties the history. After reset `fine_word` and `coarse_time` read zero, `spk_ready` is high, `ev_valid` is low and no query slot reports a hit.
- R2: The first spike accepted after reset raises no event. It loads `coarse_time` with the spike time, and `fine_word` then holds only bit 8.
- R3: `fine_word` places the history in bits [31:8]. Bits [7:0] are zero. Bit 8 is the newest slot, at `coarse_time`, and bit 8+k stands for `coarse_time` - 2k ms. Whenever the block is ready and the history is not empty, bit 8 is set.
- R4: A spike at time t that is accepted while the history is not empty shifts the history toward higher bits by floor((t - coarse_time) / 2) positions. The difference is taken modulo 2^32. The block then sets bit 8 and loads `coarse_time` with t.
- R5: Every set history bit that is pushed past bit 31 raises exactly one event. The event time is the old coarse time minus 2k ms, where k is the bit's index above bit 8 before the shift.
- R6: Events belonging to one update leave oldest first, so their times strictly increase.
- R7: While `ev_valid` is high and `ev_ready` is low, `ev_valid` stays high, `ev_time` holds, and the update does not progress.
- R8: A shift of 24 or more positions flushes every earlier spike as an event. The history afterwards holds only bit 8.
- R9: A spike less than 2 ms after the coarse time shifts nothing and raises no event. It still replaces `coarse_time` with its own time.
- R10: `spk_ready` stays low from an accepted spike that needs a shift until that update completes. `coarse_time` does not change during that interval.
- R11: For a query slot s, `q_hit` equals history bit 8+s and `q_time` equals `coarse_time` - 2s, modulo 2^32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| spk_valid | input | 1 | New spike offered |
| spk_ready | output | 1 | Block can accept a spike |
| spk_time | input | 32 | Spike time in ms |
| ev_valid | output | 1 | Learning-trigger event present |
| ev_ready | input | 1 | Consumer takes the event |
| ev_time | output | 32 | Time of the departing spike in ms |
| q_slot | input | 5 | History slot to query, 0 = newest |
| q_hit | output | 1 | Queried slot holds a spike |
| q_time | output | 32 | Time the queried slot stands for |
| fine_word | output | 32 | History bit map in bits [31:8] |
| coarse_time | output | 32 | Time of the most recent spike |

## Verification
The bench builds the block with its default values: a 24-slot history, 2 ms slots, 32-bit times and 8 zero padding bits. With a 24-slot history, a single gap of 48 ms or more reaches the saturated flush. A spike stamped just below 2^32 followed by one at 2 ms reaches the modular wrap of the time difference. A 1 ms gap exercises the sub-slot case, and shifts of 1, 2, 3, 20 and 22 slots send single and multiple set bits out of the top in a known order.

// File: rtl/sht_pkg.sv
package sht_pkg;

    typedef enum logic [1:0] {
        ST_EMPTY,
        ST_IDLE,
        ST_SHIFT,
        ST_EMIT
    } sht_state_e;

    typedef enum logic [2:0] {
        HOP_HOLD,
        HOP_CLEAR,
        HOP_SEED,
        HOP_SHIFT,
        HOP_SHIFT_SEED
    } hist_op_e;

endpackage

// File: rtl/sht_delta_calc.sv
module sht_delta_calc #(
    parameter int TW        = 32,
    parameter int HIST_BITS = 24,
    parameter int RES_LOG2  = 1,
    parameter int CW        = $clog2(HIST_BITS + 1)
) (
    input  logic [TW-1:0] now_time,
    input  logic [TW-1:0] last_time,
    output logic [CW-1:0] steps
);
    logic [TW-1:0] diff;
    logic [TW-1:0] slots;

    always_comb begin
        diff  = now_time - last_time;
        slots = diff >> RES_LOG2;
        if (slots >= TW'(HIST_BITS)) begin
            steps = CW'(HIST_BITS);
        end else begin
            steps = slots[CW-1:0];
        end
    end
endmodule

// File: rtl/sht_history_reg.sv
module sht_history_reg
    import sht_pkg::*;
#(
    parameter int HIST_BITS = 24
) (
    input  logic                 clk,
    input  logic                 rst,
    input  hist_op_e             op,
    output logic [HIST_BITS-1:0] hist_q,
    output logic                 top_bit,
    output logic                 empty
);
    localparam logic [HIST_BITS-1:0] SEED_V = HIST_BITS'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            hist_q <= '0;
        end else begin
            unique case (op)
                HOP_HOLD:       hist_q <= hist_q;
                HOP_CLEAR:      hist_q <= '0;
                HOP_SEED:       hist_q <= SEED_V;
                HOP_SHIFT:      hist_q <= {hist_q[HIST_BITS-2:0], 1'b0};
                HOP_SHIFT_SEED: hist_q <= {hist_q[HIST_BITS-2:0], 1'b1};
                default:        hist_q <= hist_q;
            endcase
        end
    end

    assign top_bit = hist_q[HIST_BITS-1];
    assign empty   = (hist_q == '0);
endmodule

// File: rtl/sht_event_clock.sv
module sht_event_clock #(
    parameter int TW        = 32,
    parameter int HIST_BITS = 24,
    parameter int RES_LOG2  = 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [TW-1:0] anchor,
    input  logic          advance,
    output logic [TW-1:0] slot_time
);
    localparam int STEP_MS = 1 << RES_LOG2;
    localparam logic [TW-1:0] SPAN = TW'(STEP_MS * (HIST_BITS - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            slot_time <= '0;
        end else if (load) begin
            slot_time <= anchor - SPAN;
        end else if (advance) begin
            slot_time <= slot_time + TW'(STEP_MS);
        end
    end
endmodule

// File: rtl/stdp_hist_tracker.sv
module stdp_hist_tracker
    import sht_pkg::*;
#(
    parameter int TW        = 32,
    parameter int HIST_BITS = 24,
    parameter int LOW_PAD   = 8,
    parameter int RES_LOG2  = 1,
    localparam int WORD_W   = HIST_BITS + LOW_PAD,
    localparam int SW       = $clog2(HIST_BITS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              spk_valid,
    output logic              spk_ready,
    input  logic [TW-1:0]     spk_time,
    output logic              ev_valid,
    input  logic              ev_ready,
    output logic [TW-1:0]     ev_time,
    input  logic [SW-1:0]     q_slot,
    output logic              q_hit,
    output logic [TW-1:0]     q_time,
    output logic [WORD_W-1:0] fine_word,
    output logic [TW-1:0]     coarse_time
);
    localparam int CW = $clog2(HIST_BITS + 1);

    sht_state_e state_q, state_d;
    hist_op_e   hop;

    logic [TW-1:0]        coarse_q;
    logic [TW-1:0]        target_q;
    logic [CW-1:0]        steps_q;
    logic [CW-1:0]        steps_in;
    logic [HIST_BITS-1:0] hist_q;
    logic                 hist_top;
    logic                 hist_empty;

    logic take_spike;
    logic coarse_from_in;
    logic coarse_from_tgt;
    logic ev_load;
    logic ev_adv;
    logic step_dec;

    sht_delta_calc #(
        .TW(TW), .HIST_BITS(HIST_BITS), .RES_LOG2(RES_LOG2), .CW(CW)
    ) u_delta (
        .now_time (spk_time),
        .last_time(coarse_q),
        .steps    (steps_in)
    );

    sht_history_reg #(.HIST_BITS(HIST_BITS)) u_hist (
        .clk    (clk),
        .rst    (rst),
        .op     (hop),
        .hist_q (hist_q),
        .top_bit(hist_top),
        .empty  (hist_empty)
    );

    sht_event_clock #(
        .TW(TW), .HIST_BITS(HIST_BITS), .RES_LOG2(RES_LOG2)
    ) u_evclk (
        .clk      (clk),
        .rst      (rst),
        .load     (ev_load),
        .anchor   (coarse_q),
        .advance  (ev_adv),
        .slot_time(ev_time)
    );

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_EMPTY;
        end else begin
            state_q <= state_d;
        end
    end

    // next state and control outputs
    always_comb begin
        state_d         = state_q;
        hop             = HOP_HOLD;
        take_spike      = 1'b0;
        coarse_from_in  = 1'b0;
        coarse_from_tgt = 1'b0;
        ev_load         = 1'b0;
        ev_adv          = 1'b0;
        step_dec        = 1'b0;
        unique case (state_q)
            ST_EMPTY: begin
                if (spk_valid) begin
                    hop            = HOP_SEED;
                    coarse_from_in = 1'b1;
                    state_d        = ST_IDLE;
                end
            end
            ST_IDLE: begin
                if (spk_valid) begin
                    if (steps_in == '0) begin
                        coarse_from_in = 1'b1;
                    end else begin
                        take_spike = 1'b1;
                        ev_load    = 1'b1;
                        state_d    = ST_SHIFT;
                    end
                end
            end
            ST_SHIFT: begin
                if (hist_empty) begin
                    hop             = HOP_SEED;
                    coarse_from_tgt = 1'b1;
                    state_d         = ST_IDLE;
                end else if (hist_top) begin
                    state_d = ST_EMIT;
                end else begin
                    ev_adv = 1'b1;
                    if (steps_q == CW'(1)) begin
                        hop             = HOP_SHIFT_SEED;
                        coarse_from_tgt = 1'b1;
                        state_d         = ST_IDLE;
                    end else begin
                        hop      = HOP_SHIFT;
                        step_dec = 1'b1;
                    end
                end
            end
            ST_EMIT: begin
                if (ev_ready) begin
                    ev_adv = 1'b1;
                    if (steps_q == CW'(1)) begin
                        hop             = HOP_SHIFT_SEED;
                        coarse_from_tgt = 1'b1;
                        state_d         = ST_IDLE;
                    end else begin
                        hop      = HOP_SHIFT;
                        step_dec = 1'b1;
                        state_d  = ST_SHIFT;
                    end
                end
            end
            default: state_d = ST_EMPTY;
        endcase
    end

    // datapath registers
    always_ff @(posedge clk) begin
        if (rst) begin
            coarse_q <= '0;
            target_q <= '0;
            steps_q  <= '0;
        end else begin
            if (coarse_from_in) begin
                coarse_q <= spk_time;
            end else if (coarse_from_tgt) begin
                coarse_q <= target_q;
            end
            if (take_spike) begin
                target_q <= spk_time;
                steps_q  <= steps_in;
            end else if (step_dec) begin
                steps_q <= steps_q - CW'(1);
            end
        end
    end

    assign spk_ready   = (state_q == ST_EMPTY) || (state_q == ST_IDLE);
    assign ev_valid    = (state_q == ST_EMIT);
    assign fine_word   = {hist_q, {LOW_PAD{1'b0}}};
    assign coarse_time = coarse_q;

    always_comb begin
        q_time = coarse_q - (TW'(q_slot) << RES_LOG2);
        if (int'(q_slot) < HIST_BITS) begin
            q_hit = hist_q[q_slot];
        end else begin
            q_hit = 1'b0;
        end
    end
endmodule

// File: rtl/sht_checker.sv
module sht_checker #(
    parameter int TW      = 32,
    parameter int WORD_W  = 32,
    parameter int LOW_PAD = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              spk_valid,
    input logic              spk_ready,
    input logic [TW-1:0]     spk_time,
    input logic              ev_valid,
    input logic              ev_ready,
    input logic [TW-1:0]     ev_time,
    input logic [WORD_W-1:0] fine_word,
    input logic [TW-1:0]     coarse_time
);
    localparam logic [WORD_W-1:0] SEED_W = WORD_W'(1) << LOW_PAD;

    // R1
    a_r1_reset_quiet: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (spk_ready && !ev_valid && fine_word == '0));

    // R2
    a_r2_first_seed: assert property (@(posedge clk) disable iff (rst)
        (spk_valid && spk_ready && fine_word == '0)
        |=> (fine_word == SEED_W && coarse_time == $past(spk_time)));

    // R3
    a_r3_anchor_bit: assert property (@(posedge clk) disable iff (rst)
        (spk_ready && fine_word != '0) |-> fine_word[LOW_PAD]);

    // R7
    a_r7_hold_event: assert property (@(posedge clk) disable iff (rst)
        (ev_valid && !ev_ready) |=> (ev_valid && $stable(ev_time)));

    // R10
    a_r10_busy_excl: assert property (@(posedge clk) disable iff (rst)
        ev_valid |-> !spk_ready);

    // R10
    a_r10_coarse_frozen: assert property (@(posedge clk) disable iff (rst)
        !spk_ready |=> (spk_ready || $stable(coarse_time)));
endmodule

bind stdp_hist_tracker sht_checker #(
    .TW(TW), .WORD_W(WORD_W), .LOW_PAD(LOW_PAD)
) u_sht_chk (
    .clk        (clk),
    .rst        (rst),
    .spk_valid  (spk_valid),
    .spk_ready  (spk_ready),
    .spk_time   (spk_time),
    .ev_valid   (ev_valid),
    .ev_ready   (ev_ready),
    .ev_time    (ev_time),
    .fine_word  (fine_word),
    .coarse_time(coarse_time)
);

// File: tb/test_stdp_hist_tracker.sv
module test_stdp_hist_tracker;
    localparam int CLK_PERIOD = 10;
    localparam int WD_LIMIT   = 20000;
    localparam int NV         = 11;

    // {spike time, event count, first event time, last event time, history bits}
    localparam logic [159:0] VEC [NV] = '{
        {32'd100, 32'd0, 32'd0,   32'd0,   32'h000001}, // R2 first spike
        {32'd104, 32'd0, 32'd0,   32'd0,   32'h000005}, // R4 shift 2
        {32'd105, 32'd0, 32'd0,   32'd0,   32'h000005}, // R9 1 ms gap
        {32'd145, 32'd0, 32'd0,   32'd0,   32'h500001}, // R4 shift 20
        {32'd149, 32'd1, 32'd101, 32'd101, 32'h400005}, // R5 one leaves
        {32'd151, 32'd0, 32'd0,   32'd0,   32'h80000B}, // R4 shift 1
        {32'd157, 32'd1, 32'd105, 32'd105, 32'h000059}, // R5 top bit leaves
        {32'd201, 32'd3, 32'd145, 32'd151, 32'h400001}, // R6 three leave
        {32'd301, 32'd2, 32'd157, 32'd201, 32'h000001}, // R8 flush
        {32'd302, 32'd0, 32'd0,   32'd0,   32'h000001}, // R9
        {32'd303, 32'd0, 32'd0,   32'd0,   32'h000001}  // R9
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        spk_valid = 1'b0;
    logic        spk_ready;
    logic [31:0] spk_time = '0;
    logic        ev_valid;
    logic        ev_ready = 1'b1;
    logic [31:0] ev_time;
    logic [4:0]  q_slot = '0;
    logic        q_hit;
    logic [31:0] q_time;
    logic [31:0] fine_word;
    logic [31:0] coarse_time;

    int total = 0;
    int bad = 0;
    int cycles = 0;
    bit done = 1'b0;

    stdp_hist_tracker i_stdp_hist_tracker (
        .clk(clk), .rst(rst),
        .spk_valid(spk_valid), .spk_ready(spk_ready), .spk_time(spk_time),
        .ev_valid(ev_valid), .ev_ready(ev_ready), .ev_time(ev_time),
        .q_slot(q_slot), .q_hit(q_hit), .q_time(q_time),
        .fine_word(fine_word), .coarse_time(coarse_time)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic drive_spike(input logic [31:0] t);
        @(negedge clk);
        while (!spk_ready) @(negedge clk);
        spk_valid = 1'b1;
        spk_time  = t;
        @(negedge clk);
        spk_valid = 1'b0;
    endtask

    task automatic collect(output int n, output logic [31:0] first, output logic [31:0] last);
        logic [31:0] prev;
        n = 0; first = '0; last = '0; prev = '0;
        while (!spk_ready) begin
            if (ev_valid && ev_ready) begin
                if (n == 0) first = ev_time;
                else check("R6 order", 32'(ev_time > prev), 32'd1);
                prev = ev_time;
                last = ev_time;
                n++;
            end
            @(negedge clk);
        end
    endtask

    initial begin
        while (!done) begin
            @(posedge clk);
            cycles++;
            if (cycles > WD_LIMIT) begin
                bad++;
                total++;
                $display("FAIL R10 watchdog: cycles=%0d expected<%0d", cycles, WD_LIMIT);
                $display("  test done: total=%0d bad=%0d", total, bad);
                $finish;
            end
        end
    end

    initial begin
        int n;
        logic [31:0] f, l;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check("R1 ready", 32'(spk_ready), 32'd1);
        check("R1 ev_valid", 32'(ev_valid), 32'd0);
        check("R1 fine", fine_word, 32'h0);
        check("R1 coarse", coarse_time, 32'h0);
        check("R1 q_hit", 32'(q_hit), 32'd0);

        for (int i = 0; i < NV; i++) begin
            drive_spike(VEC[i][159:128]);
            collect(n, f, l);
            check($sformatf("R5 row%0d count", i), 32'(n), VEC[i][127:96]);
            if (VEC[i][127:96] != 0) begin
                check($sformatf("R5 row%0d first", i), f, VEC[i][95:64]);
                check($sformatf("R6 row%0d last", i), l, VEC[i][63:32]);
            end
            check($sformatf("R4 row%0d fine", i), fine_word, VEC[i][31:0] << 8);
            check($sformatf("R3 row%0d coarse", i), coarse_time, VEC[i][159:128]);
        end

        // R7 stall: spike 351 pushes the slot-0 spike at 303 out
        ev_ready = 1'b0;
        drive_spike(32'd351);
        for (int k = 0; k < 40 && !ev_valid; k++) @(negedge clk);
        for (int k = 0; k < 4; k++) begin
            check("R7 valid held", 32'(ev_valid), 32'd1);
            check("R7 time held", ev_time, 32'd303);
            check("R10 busy", 32'(spk_ready), 32'd0);
            check("R10 coarse frozen", coarse_time, 32'd303);
            @(negedge clk);
        end
        ev_ready = 1'b1;
        collect(n, f, l);
        check("R7 count", 32'(n), 32'd1);
        check("R7 time", f, 32'd303);
        check("R8 fine", fine_word, 32'h100);

        // R11 query
        drive_spike(32'd355);
        collect(n, f, l);
        check("R4 fine 355", fine_word, 32'h500);
        q_slot = 5'd0; #1;
        check("R11 slot0 hit", 32'(q_hit), 32'd1);
        check("R11 slot0 time", q_time, 32'd355);
        q_slot = 5'd1; #1;
        check("R11 slot1 hit", 32'(q_hit), 32'd0);
        q_slot = 5'd2; #1;
        check("R11 slot2 hit", 32'(q_hit), 32'd1);
        check("R11 slot2 time", q_time, 32'd351);
        q_slot = 5'd23; #1;
        check("R11 slot23 hit", 32'(q_hit), 32'd0);
        check("R11 slot23 time", q_time, 32'd309);
        q_slot = 5'd0;

        // R8 flush near the top of the time range, then R4 across the wrap
        drive_spike(32'hFFFF_FFFE);
        collect(n, f, l);
        check("R8 wrap count", 32'(n), 32'd2);
        check("R8 wrap first", f, 32'd351);
        check("R8 wrap last", l, 32'd355);
        drive_spike(32'd2);
        collect(n, f, l);
        check("R4 wrap count", 32'(n), 32'd0);
        check("R4 wrap fine", fine_word, 32'h500);
        q_slot = 5'd2; #1;
        check("R11 wrap time", q_time, 32'hFFFF_FFFE);
        q_slot = 5'd0;

        // R1 reset during a stalled update, then R2 seeding
        ev_ready = 1'b0;
        drive_spike(32'd50);
        for (int k = 0; k < 40 && !ev_valid; k++) @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        ev_ready = 1'b1;
        @(negedge clk);
        check("R1 mid ready", 32'(spk_ready), 32'd1);
        check("R1 mid ev_valid", 32'(ev_valid), 32'd0);
        check("R1 mid fine", fine_word, 32'h0);
        check("R1 mid q_hit", 32'(q_hit), 32'd0);
        drive_spike(32'd7);
        collect(n, f, l);
        check("R2 count", 32'(n), 32'd0);
        check("R2 fine", fine_word, 32'h100);
        check("R2 coarse", coarse_time, 32'd7);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule